// File: doc/BRIEF.md
# Pipelined ADC Stage-Code Combiner

This block sits behind a multi-stage pipelined analog-to-digital converter and turns the raw decisions of its stages into one 12-bit sample on every clock. The pipeline has three kinds of stage. A 4-bit front stage comes first. Eight 1.5-bit stages follow it, and a 3-bit flash stage closes the pipeline. Every stage except the flash carries one redundant bit. Because of that bit, a wrong comparator decision in one stage is absorbed by the stages after it.

The stages decide on a given analog sample one clock apart. The front stage decides first and the flash stage decides last. The block holds each stage's code in its own delay line until all codes of one sample are present together. It then adds the codes with adjacent weights overlapping by one bit. It removes the midpoint offset of the 1.5-bit stages, drops the surplus low-order resolution and clamps the result to the 12-bit output range.

Integration is simple. Connect each stage's code bus to the block, clock the block with the sample clock, and read `result` whenever `result_valid` is high.

Top module: `pipe_adc_merge`

## Requirements
- R1: For one sample, let F be the front code (0..15), M1..M8 the 1.5-bit codes (M1 nearest the front) and L the flash code (0..7). The raw sum is S = F*1024 + sum over j of Mj*2^(10-j) + L.
- R2: The output is (S - 1020) shifted right by two bits. The value 1020 is the sum of the 1.5-bit stage weights.
- R3: If S - 1020 is negative, the output is 0.
- R4: If (S - 1020) >> 2 exceeds 4095, the output is 4095.
- R5: A 1.5-bit code is two bits with legal values 0, 1 and 2. The value 3 is treated exactly as 2. Stage j occupies bits [2j-1:2j-2] of `mid_codes`.
- R6: For one sample, stage k's code (front = 0, 1.5-bit stages = 1..8, flash = 9) is presented k clocks after the front code. The result for that sample appears after the tenth rising edge counted from the edge that captured its front code.
- R7: A new sample may start on every clock. Back-to-back samples give back-to-back results with no gaps.
- R8: `rst` is synchronous and active high. It forces `result` to 0 and `result_valid` to 0. After release, `result_valid` rises after the tenth rising edge and stays high until the next reset.
- R9: Two code sets with the same weighted sum S produce the same output. This holds, for example, when a stage decides one step high and the following stage compensates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| front_code | input | 4 | Code from the 4-bit front stage |
| mid_codes | input | 16 | Eight 2-bit codes of the 1.5-bit stages; stage 1 in the low bits |
| flash_code | input | 3 | Code from the final 3-bit flash stage |
| result | output | 12 | Corrected, saturated sample |
| result_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
A delay line that is one stage too short or too long mixes codes from neighbouring samples. With a stream of differing samples, this shows up in the first valid result, ten edges after the stream starts. A wrong weight, offset or clamp changes the very next result for any pattern that uses the affected stage. The all-zero and all-maximum patterns expose the saturation paths on the same clock. A fill counter that is wrong moves the rising edge of `result_valid` away from the tenth edge after reset.

// File: rtl/pipe_adc_merge.sv
module pipe_adc_merge #(
  parameter int N_MID   = 8,
  parameter int FRONT_W = 4,
  parameter int FLASH_W = 3,
  parameter int OUT_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FRONT_W-1:0]   front_code,
  input  logic [2*N_MID-1:0]   mid_codes,
  input  logic [FLASH_W-1:0]   flash_code,
  output logic [OUT_W-1:0]     result,
  output logic                 result_valid
);
  localparam int LAST     = N_MID + 1;
  localparam int FLASH_SH = FLASH_W - 1;
  localparam int FRONT_SH = FLASH_SH + N_MID;
  localparam int RES_BITS = (FRONT_W - 1) + N_MID + FLASH_W;
  localparam int DROP     = RES_BITS - OUT_W;
  localparam int SUM_W    = FRONT_W + FRONT_SH + 2;
  localparam int OFFSET   = (1 << FRONT_SH) - (1 << FLASH_SH);
  localparam int MAXV     = (1 << OUT_W) - 1;
  localparam int CNT_W    = $clog2(LAST + 2);

  logic [FRONT_W-1:0]          front_dl [LAST];
  logic [FRONT_W-1:0]          front_al;
  logic [N_MID-1:0][1:0]       mid_al;
  logic signed [SUM_W-1:0]     acc;
  logic signed [SUM_W-1:0]     scaled;
  logic [OUT_W-1:0]            res_d;
  logic [CNT_W-1:0]            fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAST; i++) front_dl[i] <= '0;
    end else begin
      front_dl[0] <= front_code;
      for (int i = 1; i < LAST; i++) front_dl[i] <= front_dl[i-1];
    end
  end
  assign front_al = front_dl[LAST-1];

  for (genvar j = 1; j <= N_MID; j++) begin : g_mid
    localparam int DEPTH = LAST - j;
    logic [1:0] raw;
    logic [1:0] fixed;
    logic [1:0] dl [DEPTH];
    assign raw   = mid_codes[2*(j-1) +: 2];
    assign fixed = (raw == 2'd3) ? 2'd2 : raw;
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) dl[i] <= '0;
      end else begin
        dl[0] <= fixed;
        for (int i = 1; i < DEPTH; i++) dl[i] <= dl[i-1];
      end
    end
    assign mid_al[j-1] = dl[DEPTH-1];
  end

  always_comb begin
    acc = SUM_W'(front_al) << FRONT_SH;
    for (int j = 1; j <= N_MID; j++)
      acc = acc + (SUM_W'(mid_al[j-1]) << (FRONT_SH - j));
    acc = acc + SUM_W'(flash_code) - SUM_W'(OFFSET);
  end

  assign scaled = acc >>> DROP;

  always_comb begin
    if (acc[SUM_W-1])                res_d = '0;
    else if (scaled > SUM_W'(MAXV))  res_d = OUT_W'(MAXV);
    else                             res_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fill   <= '0;
    end else begin
      result <= res_d;
      if (fill != CNT_W'(LAST + 1)) fill <= fill + 1'b1;
    end
  end

  assign result_valid = (fill == CNT_W'(LAST + 1));
endmodule

module pipe_adc_merge_chk #(
  parameter int N_MID   = 8,
  parameter int FRONT_W = 4,
  parameter int OUT_W   = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [FRONT_W-1:0]   front_al,
  input logic [N_MID-1:0][1:0] mid_al,
  input logic [OUT_W-1:0]     result,
  input logic                 result_valid
);
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!result_valid && result == '0));

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> result_valid);

  for (genvar j = 0; j < N_MID; j++) begin : g_clamp
    assert_no_code3_R5: assert property (@(posedge clk) disable iff (rst)
      mid_al[j] != 2'd3);
  end

  assert_floor_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (front_al == '0 && mid_al == '0) |=> result == '0);

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
    (front_al == '1 && mid_al == {N_MID{2'd2}}) |=> result == '1);
endmodule

bind pipe_adc_merge pipe_adc_merge_chk #(
  .N_MID(N_MID), .FRONT_W(FRONT_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .front_al(front_al), .mid_al(mid_al),
  .result(result), .result_valid(result_valid)
);

// File: tb/tb_pipe_adc_merge.sv
module tb_pipe_adc_merge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  front_code = '0;
  logic [15:0] mid_codes = '0;
  logic [2:0]  flash_code = '0;
  logic [11:0] result;
  logic        result_valid;

  int n_cmp = 0;
  int n_bad = 0;

  int s0 [64];
  int sm [64][8];
  int sf [64];
  int got [64];

  pipe_adc_merge dut (
    .clk(clk), .rst(rst), .front_code(front_code), .mid_codes(mid_codes),
    .flash_code(flash_code), .result(result), .result_valid(result_valid)
  );

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int idx);
    int s;
    int d;
    s = s0[idx] * 1024 + sf[idx];
    for (int j = 1; j <= 8; j++) s += ((sm[idx][j-1] == 3) ? 2 : sm[idx][j-1]) << (10 - j);
    d = s - 1020;
    if (d < 0) return 0;
    d = d >> 2;
    return (d > 4095) ? 4095 : d;
  endfunction

  task automatic set_sample(input int i, input int f, input int m, input int l);
    s0[i] = f;
    sf[i] = l;
    for (int j = 0; j < 8; j++) sm[i][j] = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    front_code = '0; mid_codes = '0; flash_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset result", int'(result), 0);
    check("R8 reset valid", int'(result_valid), 0);
    rst = 1'b0;
  endtask

  task automatic play(input int ns, input string tag);
    do_reset();
    for (int n = 0; n < ns + 9; n++) begin
      front_code = (n < ns) ? 4'(s0[n]) : 4'd0;
      for (int j = 1; j <= 8; j++)
        mid_codes[2*(j-1) +: 2] = (n - j >= 0 && n - j < ns) ? 2'(sm[n-j][j-1]) : 2'd0;
      flash_code = (n - 9 >= 0 && n - 9 < ns) ? 3'(sf[n-9]) : 3'd0;
      @(posedge clk);
      @(negedge clk);
      check({tag, " R8 valid timing"}, int'(result_valid), (n >= 9) ? 1 : 0);
      if (n >= 9) begin
        got[n-9] = int'(result);
        check({tag, " R6 R1 R2 data"}, int'(result), model(n - 9));
      end
    end
  endtask

  task automatic t_fixed();
    set_sample(0, 0, 0, 0);
    set_sample(1, 15, 2, 7);
    set_sample(2, 8, 1, 4);
    set_sample(3, 0, 1, 3);
    set_sample(4, 15, 0, 0);
    play(5, "fixed");
    check("R3 floor", got[0], 0);
    check("R4 ceiling", got[1], 4095);
    check("R2 midscale", got[2], 2049);
    check("R2 low edge", got[3], 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 48; i++) begin
      s0[i] = int'($urandom_range(15, 0));
      sf[i] = int'($urandom_range(7, 0));
      for (int j = 0; j < 8; j++) sm[i][j] = int'($urandom_range(3, 0));
    end
    play(48, "random R7 R5");
  endtask

  task automatic t_redundancy();
    set_sample(0, 5, 1, 3); sm[0][0] = 2; sm[0][1] = 0;
    set_sample(1, 5, 1, 3); sm[1][0] = 1; sm[1][1] = 2;
    set_sample(2, 4, 1, 6); sm[2][0] = 2;
    set_sample(3, 5, 1, 6); sm[3][0] = 0;
    play(4, "redund");
    check("R9 mid stage error absorbed", got[0], got[1]);
    check("R9 front stage error absorbed", got[2], got[3]);
  endtask

  task automatic t_clamp();
    set_sample(0, 9, 3, 5);
    set_sample(1, 9, 2, 5);
    set_sample(2, 2, 3, 1);
    sm[2][3] = 0;
    play(3, "clamp");
    check("R5 code 3 equals 2", got[0], got[1]);
  endtask

  task automatic t_mid_reset();
    set_sample(0, 7, 1, 2);
    do_reset();
    front_code = 4'd7;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R8 valid before reset", int'(result_valid), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 mid-run reset valid", int'(result_valid), 0);
    check("R8 mid-run reset result", int'(result), 0);
    rst = 1'b0;
    front_code = '0;
  endtask

  initial begin
    t_fixed();
    t_random();
    t_redundancy();
    t_clamp();
    t_mid_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule